// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block acts as the target side of a two-wire bus and behaves like a small serial EEPROM. A fast system clock oversamples the clock line and the data line through a synchronizer. The synchronized lines are compared with their previous values to find clock edges and START and STOP conditions. A bit-level state machine receives the device byte and the word address, stores single data bytes into an internal byte array, and returns stored bytes on read. The data line is only ever pulled low: the block drives one output that enables an external open-drain pull-down.

A write transfer has three or four bytes: the device byte with the direction bit clear, then the word address, then one data byte, then STOP. The word address is two bytes, high byte first, when `addr16_i` is 1, and one byte when it is 0. A random read begins with the same device byte and word address, with no data byte (a dummy write). A repeated START follows, then the device byte with the direction bit set. The target then shifts out the stored byte. A second debug port reads the array directly, so the bench can see memory contents without using the bus.

The state machine has these states. `S_IDLE` waits for START. `S_DEV` receives the device byte. `S_AHI` and `S_ALO` receive the high and low word-address bytes. `S_WDAT` receives the data byte. `S_ACK` holds SDA low for the acknowledge clock. `S_RDAT` shifts a read byte out. `S_MACK` samples the master's acknowledge. `S_WAIT` ignores the bus. Its transitions are as follows:
- START moves any state to `S_DEV`, and STOP moves any state to `S_IDLE`.
- A completed matching device byte moves `S_DEV` to `S_ACK`. A completed non-matching one moves it to `S_WAIT`.
- A completed byte in `S_AHI`, `S_ALO` or `S_WDAT` moves to `S_ACK`.
- `S_ACK` leaves on the ninth SCL fall to the state it recorded. That is `S_AHI` or `S_ALO` after the device byte, `S_ALO` after the high address byte, `S_WDAT` after the low address byte, `S_WAIT` after the data byte, and `S_RDAT` after a read device byte.
- `S_RDAT` moves to `S_MACK` after eight SCL falls.
- `S_MACK` returns to `S_RDAT` on an acknowledge, and moves to `S_WAIT` on a not-acknowledge.

Top module: `i2c_eeprom_target`

## Requirements
- R1: While `rst_n` is low and after it is released, `sda_pull_o` is 0 until a START is seen. The target starts in `S_IDLE`.
- R2: When the first byte after START has its upper seven bits (sent first) equal to `DEV_ADDR` (default 7'b1010000), the target pulls SDA low for the ninth SCL clock.
- R3: When those seven bits do not match, the target does not pull SDA on any later clock. It stores nothing until the next START.
- R4: With the direction bit (eighth bit) 0, the word address follows the device byte, then one data byte. The word address is two bytes, high first, when `addr16_i`=1. It is one byte when `addr16_i`=0, and the high byte is then cleared. Each byte is acknowledged, and the data byte is written on the ninth SCL fall's preceding fall edge.
- R5: The array index is the low `ADDR_W` bits of the 16-bit word address, `{high, low}`. With `ADDR_W`=13 the index is 5 bits of the high byte followed by the low byte. Addresses above the array alias.
- R6: A dummy write, then a repeated START, then the device byte with direction bit 1 makes the target return the byte at the loaded word address, MSB first. Each bit changes only while SCL is low.
- R7: After a read byte the target increments the word address. A master acknowledge (SDA low on the ninth clock) returns the next byte, with the index wrapping at 2^`ADDR_W`. A not-acknowledge releases SDA, and the target waits for STOP.
- R8: A second data byte in a write transfer is not acknowledged and not stored.
- R9: A START or STOP in the middle of a byte abandons it and clears the bit count. The next transfer then works normally.
- R10: `sda_pull_o` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr16_i | input | 1 | 1 selects a two-byte word address, 0 a one-byte word address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | Pull-down enable for the open-drain data line |
| dbg_addr_i | input | ADDR_W | Debug read index into the byte array |
| dbg_data_o | output | 8 | Byte stored at `dbg_addr_i` |

## Verification
A table of write-then-random-read pairs exercises the main path in both address widths. Its data patterns are 0xA5, 0x5A, 0x3C, 0x81, 0x00 and 0xFF, so a reversed bit order, a stuck line or a shifted byte each gives a visibly different value. The word addresses include one above the array, which tells index aliasing apart from correct storage. The narrow-mode entries tell the one-byte address phase apart from a two-byte one. Directed transfers then cover the following cases: a wrong device address, with the array read back to confirm it was left alone; a two-byte sequential read that wraps from the last index to 0; an extra data byte in a write; and bytes cut short by STOP or by START, each followed by a normal transfer.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;

    localparam int BYTE_W  = 8;
    localparam int WADDR_W = 16;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_AHI,
        S_ALO,
        S_WDAT,
        S_ACK,
        S_RDAT,
        S_MACK,
        S_WAIT
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL and SDA and flags edges and bus conditions.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [1:0] raw;
    logic [1:0] sy;
    logic [1:0] dl;

    assign raw = {scl_i, sda_i};

    // One pipe per line: STAGES synchronizer flops plus one history flop.
    for (genvar L = 0; L < 2; L++) begin : g_line
        logic [STAGES:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-1:0], raw[L]};
        end
        assign sy[L] = pipe[STAGES-1];
        assign dl[L] = pipe[STAGES];
    end

    assign scl_o      = sy[1];
    assign sda_o      = sy[0];
    assign scl_rise_o =  sy[1] & ~dl[1];
    assign scl_fall_o = ~sy[1] &  dl[1];
    assign start_o    =  sy[1] &  dl[1] &  dl[0] & ~sy[0];
    assign stop_o     =  sy[1] &  dl[1] & ~dl[0] &  sy[0];

endmodule

// File: rtl/i2c_eep_mem.sv
// Byte array: one write port, two combinational read ports.
module i2c_eep_mem #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] wa_i,
    input  logic [DATA_W-1:0] wd_i,
    input  logic [ADDR_W-1:0] ra_a_i,
    output logic [DATA_W-1:0] rd_a_o,
    input  logic [ADDR_W-1:0] ra_b_i,
    output logic [DATA_W-1:0] rd_b_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] ram [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) ram[wa_i] <= wd_i;
    end

    assign rd_a_o = ram[ra_a_i];
    assign rd_b_o = ram[ra_b_i];

endmodule

// File: rtl/i2c_tgt_fsm.sv
// Bit-level protocol engine for the EEPROM-like target.
module i2c_tgt_fsm
    import i2c_eep_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1010000,
    parameter int         ADDR_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr16_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              sda_pull_o,
    output tgt_state_e        state_o
);

    localparam logic [3:0] BITS = 4'(BYTE_W);

    tgt_state_e          state, state_nx;
    tgt_state_e          after_ack, ack_nx;
    logic [3:0]          cnt;
    logic [BYTE_W-1:0]   shreg;
    logic [BYTE_W-1:0]   tx;
    logic [WADDR_W-1:0]  waddr;
    logic                nack;
    logic                byte_done;
    logic                dev_hit;

    assign byte_done = scl_fall_i && (cnt == BITS);
    assign dev_hit   = (shreg[7:1] == DEV_ADDR);

    // Next-state and post-acknowledge destination.
    always_comb begin
        state_nx = state;
        ack_nx   = after_ack;
        if (start_i) begin
            state_nx = S_DEV;
        end else if (stop_i) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_DEV: if (byte_done) begin
                    if (!dev_hit) begin
                        state_nx = S_WAIT;
                    end else begin
                        state_nx = S_ACK;
                        ack_nx   = shreg[0] ? S_RDAT : (addr16_i ? S_AHI : S_ALO);
                    end
                end
                S_AHI: if (byte_done) begin
                    state_nx = S_ACK;
                    ack_nx   = S_ALO;
                end
                S_ALO: if (byte_done) begin
                    state_nx = S_ACK;
                    ack_nx   = S_WDAT;
                end
                S_WDAT: if (byte_done) begin
                    state_nx = S_ACK;
                    ack_nx   = S_WAIT;
                end
                S_ACK:  if (scl_fall_i) state_nx = after_ack;
                S_RDAT: if (scl_fall_i && cnt == BITS - 4'd1) state_nx = S_MACK;
                S_MACK: if (scl_fall_i) state_nx = nack ? S_WAIT : S_RDAT;
                default: ;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            after_ack <= S_IDLE;
        end else begin
            state     <= state_nx;
            after_ack <= ack_nx;
        end
    end

    // Shift registers, bit counter and word address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            tx    <= '0;
            waddr <= '0;
            nack  <= 1'b0;
        end else if (start_i || stop_i) begin
            cnt <= '0;
        end else begin
            unique case (state)
                S_DEV, S_AHI, S_ALO, S_WDAT: begin
                    if (scl_rise_i && cnt < BITS) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_i};
                        cnt   <= cnt + 4'd1;
                    end
                    if (byte_done) begin
                        cnt <= '0;
                        if (state == S_AHI) waddr[15:8] <= shreg;
                        if (state == S_ALO) waddr[7:0]  <= shreg;
                        if (state == S_DEV && dev_hit && !shreg[0] && !addr16_i)
                            waddr[15:8] <= '0;
                    end
                end
                S_ACK: if (scl_fall_i) begin
                    cnt <= '0;
                    tx  <= rd_data_i;
                end
                S_RDAT: if (scl_fall_i) begin
                    if (cnt == BITS - 4'd1) begin
                        cnt   <= '0;
                        waddr <= waddr + 16'd1;
                    end else begin
                        tx  <= {tx[BYTE_W-2:0], 1'b0};
                        cnt <= cnt + 4'd1;
                    end
                end
                S_MACK: begin
                    if (scl_rise_i) nack <= sda_i;
                    if (scl_fall_i) tx   <= rd_data_i;
                end
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        sda_pull_o  = (state == S_ACK) || (state == S_RDAT && !tx[BYTE_W-1]);
        mem_we_o    = (state == S_WDAT) && byte_done && !start_i && !stop_i;
        mem_wdata_o = shreg;
        mem_addr_o  = waddr[ADDR_W-1:0];
        state_o     = state;
    end

endmodule

// File: rtl/i2c_eeprom_target.sv
// Top: synchronizer, protocol engine and byte array.
module i2c_eeprom_target
    import i2c_eep_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1010000,
    parameter int         ADDR_W      = 10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr16_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [ADDR_W-1:0] dbg_addr_i,
    output logic [7:0]        dbg_data_o
);

    logic              scl_s, sda_s;
    logic              scl_rise, scl_fall, start_ev, stop_ev;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [BYTE_W-1:0] mem_wdata, mem_rdata;
    tgt_state_e        fsm_state;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr16_i    (addr16_i),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_ev),
        .stop_i      (stop_ev),
        .sda_i       (sda_s),
        .rd_data_i   (mem_rdata),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .sda_pull_o  (sda_pull_o),
        .state_o     (fsm_state)
    );

    i2c_eep_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
        .clk    (clk),
        .we_i   (mem_we),
        .wa_i   (mem_addr),
        .wd_i   (mem_wdata),
        .ra_a_i (mem_addr),
        .rd_a_o (mem_rdata),
        .ra_b_i (dbg_addr_i),
        .rd_b_o (dbg_data_o)
    );

endmodule

// File: rtl/i2c_eep_checker.sv
// Protocol properties for the target, bound to the top module.
module i2c_eep_checker
    import i2c_eep_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_ev,
    input logic       stop_ev,
    input logic       sda_pull,
    input logic       mem_we,
    input tgt_state_e state
);

    assert_idle_in_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !sda_pull);

    assert_pull_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !$past(scl_s));

    assert_write_on_low_scl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !scl_s);

    assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == S_DEV));

    assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == S_IDLE));

endmodule

bind i2c_eeprom_target i2c_eep_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_pull (sda_pull_o),
    .mem_we   (mem_we),
    .state    (fsm_state)
);

// File: tb/i2c_eeprom_target_bench.sv
module i2c_eeprom_target_bench;

    localparam int         AW   = 10;
    localparam int         Q    = 6;
    localparam logic [6:0] DEV  = 7'b1010000;
    localparam int         MASK = (1 << AW) - 1;
    localparam int         NVEC = 6;

    // Entry: {two-byte address mode, word address, data}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 16'h0012, 8'hA5},
        {1'b1, 16'h03FF, 8'h3C},
        {1'b0, 16'h0077, 8'h81},
        {1'b1, 16'h1405, 8'h5A},   // R5: aliases to index 0x005
        {1'b0, 16'h00FF, 8'h00},
        {1'b1, 16'h0200, 8'hFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr16 = 1'b1;
    logic          m_scl = 1'b1;
    logic          m_sda = 1'b1;
    logic [AW-1:0] dbg_addr = '0;
    logic [7:0]    dbg_data;
    logic          pull;
    wire           sda_line = m_sda & ~pull;

    int n_chk = 0;
    int n_fail = 0;
    int r10_viol = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_eeprom_target u_i2c_eeprom_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr16_i   (addr16),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_pull_o (pull),
        .dbg_addr_i (dbg_addr),
        .dbg_data_o (dbg_data)
    );

    // R10 monitor: the pull enable must not move while SCL stays high.
    logic prev_scl = 1'b1;
    logic prev_pull = 1'b0;
    always @(posedge clk) begin
        #2;
        if (rst_n && m_scl && prev_scl && pull !== prev_pull) r10_viol++;
        prev_scl  = m_scl;
        prev_pull = pull;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic nack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(nack);
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mnack);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(mnack);
    endtask

    task automatic eep_write(input logic wide, input logic [15:0] a, input logic [7:0] d,
                             output logic [3:0] nacks);
        logic n0, n1, n2, n3;
        addr16 = wide;
        bus_start();
        send_byte({DEV, 1'b0}, n0);
        n1 = 1'b0;
        if (wide) send_byte(a[15:8], n1);
        send_byte(a[7:0], n2);
        send_byte(d, n3);
        bus_stop();
        nacks = {n0, n1, n2, n3};
    endtask

    task automatic eep_read(input logic wide, input logic [15:0] a, input int nbytes,
                            output logic [15:0] dout, output logic [3:0] nacks,
                            output logic pull_after);
        logic n0, n1, n2, n3;
        logic [7:0] b0, b1;
        addr16 = wide;
        bus_start();
        send_byte({DEV, 1'b0}, n0);
        n1 = 1'b0;
        if (wide) send_byte(a[15:8], n1);
        send_byte(a[7:0], n2);
        bus_start();
        send_byte({DEV, 1'b1}, n3);
        b1 = 8'h00;
        recv_byte(b0, nbytes == 1);
        if (nbytes == 2) recv_byte(b1, 1'b1);
        tick(2);
        pull_after = pull;
        bus_stop();
        dout  = (nbytes == 2) ? {b0, b1} : {8'h00, b0};
        nacks = {n0, n1, n2, n3};
    endtask

    task automatic dbg_check(input string req, input int idx, input int exp);
        dbg_addr = AW'(idx);
        tick(1);
        check(req, "debug port byte", dbg_data, exp);
    endtask

    initial begin : main
        logic [3:0]  nk;
        logic [15:0] dout;
        logic        pa, n;

        tick(3);
        check("R1", "pull during reset", pull, 0);
        rst_n = 1'b1;
        tick(4);
        check("R1", "pull after reset", pull, 0);
        check("R1", "bus line idle high", sda_line, 1);

        // Table: write each entry, check acks and storage, then random-read it back.
        for (int i = 0; i < NVEC; i++) begin
            logic        w;
            logic [15:0] a;
            logic [7:0]  d;
            {w, a, d} = VEC[i];
            eep_write(w, a, d, nk);
            check("R2", "device byte ack", nk[3], 0);
            check("R4", "address/data acks", nk[2:0], 0);
            dbg_check("R5", a & MASK, d);
            eep_read(w, a, 1, dout, nk, pa);
            check("R6", "random read data", dout[7:0], d);
            check("R6", "random read acks", nk, 0);
        end

        // R3: wrong device address is ignored; index 0x012 keeps 0xA5.
        addr16 = 1'b1;
        bus_start();
        send_byte(8'hA2, n);
        check("R3", "no ack for other device", n, 1);
        send_byte(8'h00, n);
        check("R3", "no ack on later byte", n, 1);
        send_byte(8'h12, n);
        check("R3", "no ack on later byte", n, 1);
        send_byte(8'h00, n);
        check("R3", "no ack on later byte", n, 1);
        bus_stop();
        dbg_check("R3", 16'h0012, 8'hA5);

        // R7: sequential read across the top index wraps to 0.
        eep_write(1'b1, 16'h0000, 8'h66, nk);
        check("R7", "setup write acks", nk, 0);
        eep_read(1'b1, 16'h03FF, 2, dout, nk, pa);
        check("R7", "first byte", dout[15:8], 8'h3C);
        check("R7", "wrapped second byte", dout[7:0], 8'h66);
        check("R7", "released after master nack", pa, 0);

        // R8: a second data byte is refused and not stored.
        eep_write(1'b1, 16'h0101, 8'h99, nk);
        bus_start();
        send_byte({DEV, 1'b0}, n);
        send_byte(8'h01, n);
        send_byte(8'h00, n);
        send_byte(8'h11, n);
        check("R8", "first data byte ack", n, 0);
        send_byte(8'h22, n);
        check("R8", "second data byte nack", n, 1);
        bus_stop();
        dbg_check("R8", 16'h0100, 8'h11);
        dbg_check("R8", 16'h0101, 8'h99);

        // R9: STOP in mid-byte, then a clean write.
        bus_start();
        for (int i = 7; i >= 3; i--) send_bit(DEV[i-1]);
        bus_stop();
        eep_write(1'b1, 16'h0033, 8'h44, nk);
        check("R9", "acks after stop abort", nk, 0);
        dbg_check("R9", 16'h0033, 8'h44);

        // R9: START in mid-byte, then a write from the repeated START.
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        eep_write(1'b1, 16'h0034, 8'h45, nk);
        check("R9", "acks after start abort", nk, 0);
        dbg_check("R9", 16'h0034, 8'h45);

        check("R10", "pull changes while SCL high", r10_viol, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule